// File: doc/BRIEF.md
# Serial Control Latch Updater

This block holds an 8-bit image of board control outputs and copies it into an external shift-and-latch register. The copy goes out over a clock pin and a data pin that are also wired to an I2C bus, and a third pin strobes the shifted byte onto the latch outputs. Software-facing logic writes one bit at a time through an index/value port. It then raises an update request, and the block reports `busy` while a transfer runs.

Every update sends the whole image, most significant bit first. For each bit the clock goes low, the data pin takes the bit, and the clock goes high; the external register samples on that rising edge. After the last bit the strobe is pulsed. The clock and data pins are then walked back to the I2C-idle level: clock low, data high, clock high. Every pin step is held for `SETTLE_CYC` clock cycles. The default of 300 cycles gives about 3 us at 100 MHz.

The image bits are: bit 0 and bit 1 select the internal clock for serial ports 0 and 1; bit 2 and bit 3 are the active-low terminal-ready lines of ports 0 and 1; bit 4 is a spare external control; bit 5 enables automatic reset; bit 6 is the active-low PCI reset; bit 7 is the active-low EEPROM write control.

Top module: `ctl_latch_push`

## Requirements
- R1: During reset and whenever `busy` is 0, `lat_clk_o` = 1, `lat_dat_o` = 1 and `lat_stb_o` = 0.
- R2: A transfer shifts out all 8 image bits, bit 7 first. For each bit, clock low, then data = bit value, then clock high; the bit is valid on the rising clock edge.
- R3: After the eighth rising clock edge, exactly one strobe pulse (high, then low) occurs while the clock is held high.
- R4: After the strobe, the clock goes low, the data goes high, then the clock goes high; a transfer ends with clock and data both at 1.
- R5: Each step holds for exactly `SETTLE_CYC` cycles. At most one pin changes per clock, and one transfer keeps `busy` high for 29 × `SETTLE_CYC` cycles.
- R6: Reset loads the image with 8'hCC (bits 2, 3, 6 and 7 set). That value is pushed out once without any request.
- R7: A write with `wr_en` = 1 changes only image bit `wr_idx` to `wr_val`. A write alone starts no transfer, so the pins stay idle and `busy` stays 0.
- R8: An update request seen while idle makes `busy` 1 and `lat_clk_o` 0 on the next clock.
- R9: Requests arriving while busy are merged into one pending transfer. That transfer starts right after the current one and carries the image as it stands at its start, including writes made during the earlier transfer.
- R10: A write and an update request in the same cycle send the image with that write applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one image bit |
| wr_idx | input | 3 | Index of the bit to write |
| wr_val | input | 1 | Value for the indexed bit |
| upd_req | input | 1 | Request a transfer of the image |
| busy | output | 1 | Transfer in progress |
| lat_clk_o | output | 1 | Shift clock, shared with I2C clock |
| lat_dat_o | output | 1 | Shift data, shared with I2C data |
| lat_stb_o | output | 1 | Latch strobe |

## Verification
The bench decodes the pins the way the external register would: it samples data on each clock rise and compares the byte at each strobe. A design that swapped the bit order, or sent the image taken before a same-cycle write, shows up as a byte mismatch. The bench also requires the release rise after the strobe to find data high and the lines to be idle when `busy` drops. A design that skipped the idle walk-back would therefore be reported, as would one that counted the release rise as a ninth bit. The length of `busy` is checked for a single transfer and for a transfer whose pending request was raised twice. This catches a dropped pending request, duplicated transfers and a wrong settle count. Gaps between pin changes are also checked for a short hold.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

   // image bit positions
   localparam int CB_CLKSEL0  = 0;
   localparam int CB_CLKSEL1  = 1;
   localparam int CB_RDY0_N   = 2;
   localparam int CB_RDY1_N   = 3;
   localparam int CB_EXTCTL   = 4;
   localparam int CB_AUTORST  = 5;
   localparam int CB_PCIRST_N = 6;
   localparam int CB_EEWC_N   = 7;

   localparam int IMG_BITS = 8;

   // value loaded at reset: inactive levels of the active-low controls
   localparam logic [IMG_BITS-1:0] IMG_INIT =
      IMG_BITS'((1 << CB_RDY0_N) | (1 << CB_RDY1_N) |
                (1 << CB_PCIRST_N) | (1 << CB_EEWC_N));

   // sequencer steps; the name says which pin change is made on entry
   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_CLK_LO,
      SQ_DAT_SET,
      SQ_CLK_HI,
      SQ_STB_HI,
      SQ_STB_LO,
      SQ_REL_CLK_LO,
      SQ_REL_DAT_HI,
      SQ_REL_CLK_HI
   } seq_st_e;

   localparam int STEPS_PER_BIT = 3;
   localparam int TAIL_STEPS    = 5;

endpackage

// File: rtl/ctl_shadow_reg.sv
module ctl_shadow_reg #(
   parameter int                NBITS    = 8,
   parameter logic [NBITS-1:0]  INIT_VAL = '0,
   localparam int               IW       = (NBITS > 1) ? $clog2(NBITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic             wr_val,
   output logic [NBITS-1:0] img_nxt
);

   logic [NBITS-1:0] img_q;

   // image with this cycle's write applied
   always_comb begin
      img_nxt = img_q;
      if (wr_en && (int'(wr_idx) < NBITS))
         img_nxt[wr_idx] = wr_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         img_q <= INIT_VAL;
      else
         img_q <= img_nxt;
   end

   AST_IMG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(img_q)) else $error("image changed without write"); // R7

   AST_IMG_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ($countones(img_q ^ $past(img_q)) <= 1)) else $error("write touched several bits"); // R7

   AST_IMG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (img_q[$past(wr_idx)] == $past(wr_val))) else $error("written bit wrong"); // R7

endmodule

// File: rtl/ctl_settle_timer.sv
module ctl_settle_timer #(
   parameter int SETTLE_CYC = 300,
   localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_go,
   output logic tick
);

   generate
      if (SETTLE_CYC < 1) begin : g_bad
         $error("SETTLE_CYC must be at least 1");
      end else if (SETTLE_CYC == 1) begin : g_single
         // every step lasts one cycle
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (step_go)
               cnt_q <= CW'(SETTLE_CYC - 1);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign tick = (cnt_q == '0);

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(SETTLE_CYC - 1)) else $error("settle counter out of range"); // R5

         AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            step_go |=> !tick) else $error("step ended too early"); // R5
      end
   endgenerate

endmodule

// File: rtl/ctl_shift_seq.sv
module ctl_shift_seq
   import ctl_latch_pkg::*;
#(
   parameter int NBITS = 8,
   localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_req,
   input  logic [NBITS-1:0] load_val,
   input  logic             tick,
   output logic             step_go,
   output logic             busy,
   output logic             clk_o,
   output logic             dat_o,
   output logic             stb_o
);

   seq_st_e          st_q;
   logic             pend_q;
   logic [NBITS-1:0] snap_q;
   logic [BW-1:0]    left_q;
   logic             want;
   logic             last_step;
   logic             start;

   assign busy      = (st_q != SQ_IDLE);
   assign want      = upd_req | pend_q;
   assign last_step = (st_q == SQ_REL_CLK_HI) & tick;
   assign start     = want & (~busy | last_step);
   assign step_go   = start | (busy & tick);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         pend_q <= 1'b1;          // push the reset image once
         clk_o  <= 1'b1;
         dat_o  <= 1'b1;
         stb_o  <= 1'b0;
         snap_q <= '0;
         left_q <= '0;
      end else if (start) begin
         st_q   <= SQ_CLK_LO;
         clk_o  <= 1'b0;
         snap_q <= load_val;
         left_q <= BW'(NBITS - 1);
         pend_q <= 1'b0;
      end else begin
         if (upd_req)
            pend_q <= 1'b1;
         if (busy && tick) begin
            unique case (st_q)
               SQ_CLK_LO: begin
                  st_q  <= SQ_DAT_SET;
                  dat_o <= snap_q[NBITS-1];
               end
               SQ_DAT_SET: begin
                  st_q  <= SQ_CLK_HI;
                  clk_o <= 1'b1;
               end
               SQ_CLK_HI: begin
                  if (left_q == '0) begin
                     st_q  <= SQ_STB_HI;
                     stb_o <= 1'b1;
                  end else begin
                     st_q   <= SQ_CLK_LO;
                     clk_o  <= 1'b0;
                     snap_q <= {snap_q[NBITS-2:0], 1'b0};
                     left_q <= left_q - 1'b1;
                  end
               end
               SQ_STB_HI: begin
                  st_q  <= SQ_STB_LO;
                  stb_o <= 1'b0;
               end
               SQ_STB_LO: begin
                  st_q  <= SQ_REL_CLK_LO;
                  clk_o <= 1'b0;
               end
               SQ_REL_CLK_LO: begin
                  st_q  <= SQ_REL_DAT_HI;
                  dat_o <= 1'b1;
               end
               SQ_REL_DAT_HI: begin
                  st_q  <= SQ_REL_CLK_HI;
                  clk_o <= 1'b1;
               end
               SQ_REL_CLK_HI: begin
                  st_q <= SQ_IDLE;
               end
               default: st_q <= SQ_IDLE;
            endcase
         end
      end
   end

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (clk_o && dat_o && !stb_o)) else $error("pins not idle"); // R1

   AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({clk_o, dat_o, stb_o} ^ $past({clk_o, dat_o, stb_o})) <= 1) else $error("two pins moved"); // R5

   AST_STB_CLK_HI: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |-> (clk_o && left_q == '0)) else $error("strobe with clock low or bits left"); // R3

   AST_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && upd_req) |=> (busy && !clk_o)) else $error("request not started"); // R8

   AST_REQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && upd_req && !last_step) |=> pend_q) else $error("request lost"); // R9

endmodule

// File: rtl/ctl_latch_push.sv
module ctl_latch_push
   import ctl_latch_pkg::*;
#(
   parameter int SETTLE_CYC = 300,
   localparam int NBITS = IMG_BITS,
   localparam int IW    = $clog2(NBITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_val,
   input  logic          upd_req,
   output logic          busy,
   output logic          lat_clk_o,
   output logic          lat_dat_o,
   output logic          lat_stb_o
);

   generate
      if (NBITS < 2) begin : g_bad_width
         $error("image must have at least two bits");
      end
   endgenerate

   logic [NBITS-1:0] img_nxt;
   logic             tick;
   logic             step_go;

   ctl_shadow_reg #(
      .NBITS    (NBITS),
      .INIT_VAL (IMG_INIT)
   ) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_val  (wr_val),
      .img_nxt (img_nxt)
   );

   ctl_settle_timer #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_go (step_go),
      .tick    (tick)
   );

   ctl_shift_seq #(
      .NBITS (NBITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_req  (upd_req),
      .load_val (img_nxt),
      .tick     (tick),
      .step_go  (step_go),
      .busy     (busy),
      .clk_o    (lat_clk_o),
      .dat_o    (lat_dat_o),
      .stb_o    (lat_stb_o)
   );

endmodule

// File: tb/ctl_latch_push_test.sv
module ctl_latch_push_test;

   localparam int S     = 3;
   localparam int FRAME = 29 * S;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_idx = '0;
   logic       wr_val = 1'b0;
   logic       upd_req = 1'b0;
   logic       busy, lat_clk_o, lat_dat_o, lat_stb_o;

   int n_checks = 0;
   int n_errors = 0;
   int frames = 0;
   int busy_len = 0;
   int busy_run = 0;

   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   ctl_latch_push #(.SETTLE_CYC(S)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
      .upd_req(upd_req), .busy(busy), .lat_clk_o(lat_clk_o),
      .lat_dat_o(lat_dat_o), .lat_stb_o(lat_stb_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- monitor / scoreboard ----------------
   logic       p_clk = 1'b1, p_dat = 1'b1, p_stb = 1'b0, p_busy = 1'b0;
   logic [7:0] sh = '0;
   int         nbits = 0;
   bit         post_stb = 1'b0;
   int         cyc = 0;
   int         last_chg = -1000;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         automatic int nchg = int'(lat_clk_o != p_clk) + int'(lat_dat_o != p_dat)
                              + int'(lat_stb_o != p_stb);
         if (nchg != 0) begin
            chk(nchg == 1, "R5 one pin per step", nchg, 1);
            chk(cyc - last_chg >= S, "R5 settle hold", cyc - last_chg, S);
            last_chg = cyc;
         end
         if (lat_clk_o && !p_clk) begin
            if (post_stb) begin
               chk(lat_dat_o == 1'b1, "R4 data high at release", int'(lat_dat_o), 1);
               post_stb = 1'b0;
            end else begin
               sh = {sh[6:0], lat_dat_o};
               nbits++;
            end
         end
         if (lat_stb_o && !p_stb) begin
            chk(lat_clk_o == 1'b1, "R3 strobe with clock high", int'(lat_clk_o), 1);
            chk(nbits == 8, "R2 bit count", nbits, 8);
            if (exp_q.size() == 0)
               chk(1'b0, "R2 unexpected frame", int'(sh), 0);
            else begin
               automatic logic [7:0] e = exp_q.pop_front();
               chk(sh == e, "R2 shifted byte", int'(sh), int'(e));
            end
            frames++;
            nbits = 0;
            post_stb = 1'b1;
         end
         if (busy) busy_run++;
         if (!busy && p_busy) begin
            busy_len = busy_run;
            busy_run = 0;
            chk(lat_clk_o && lat_dat_o && !lat_stb_o, "R4 lines idle at end",
                int'({lat_clk_o, lat_dat_o, lat_stb_o}), 3'b110);
         end
      end
      p_clk = lat_clk_o; p_dat = lat_dat_o; p_stb = lat_stb_o; p_busy = busy;
   end

   // ---------------- driver tasks ----------------
   task automatic write_bit(input int idx, input bit v);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_val = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_req();
      upd_req = 1'b1;
      @(negedge clk);
      upd_req = 1'b0;
   endtask

   task automatic wait_done();
      while (!busy) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      exp_q.push_back(8'hCC);                          // R6 reset image
      repeat (3) @(negedge clk);
      chk(lat_clk_o && lat_dat_o && !lat_stb_o && !busy, "R1 reset pins",
          int'({busy, lat_clk_o, lat_dat_o, lat_stb_o}), 4'b0110);
      rst_n = 1'b1;
      wait_done();
      chk(frames == 1, "R6 automatic first push", frames, 1);
      chk(busy_len == FRAME, "R5 transfer length", busy_len, FRAME);

      // R7: write alone does not start a transfer
      write_bit(0, 1'b1);
      begin
         int bad = 0;
         for (int i = 0; i < 20; i++) begin
            if (busy || !lat_clk_o || !lat_dat_o || lat_stb_o) bad++;
            @(negedge clk);
         end
         chk(bad == 0, "R7 write starts nothing", bad, 0);
      end
      chk(frames == 1, "R7 no frame from write", frames, 1);

      // R8: request from idle
      exp_q.push_back(8'hCD);
      upd_req = 1'b1;
      @(negedge clk);
      upd_req = 1'b0;
      chk(busy && !lat_clk_o, "R8 busy and clock low next cycle",
          int'({busy, lat_clk_o}), 2'b10);
      wait_done();

      // R7: several single-bit writes
      write_bit(7, 1'b0);
      write_bit(4, 1'b1);
      exp_q.push_back(8'h5D);
      pulse_req();
      wait_done();

      // R9: pending requests merge, carry mid-transfer write
      exp_q.push_back(8'h5D);
      exp_q.push_back(8'h5F);
      pulse_req();
      repeat (10) @(negedge clk);
      write_bit(1, 1'b1);
      pulse_req();
      repeat (5) @(negedge clk);
      pulse_req();
      wait_done();
      chk(busy_len == 2 * FRAME, "R9 one merged follow-up", busy_len, 2 * FRAME);
      chk(frames == 5, "R9 frame count", frames, 5);

      // R10: write and request in the same cycle
      exp_q.push_back(8'h5E);
      wr_en = 1'b1; wr_idx = 3'd0; wr_val = 1'b0; upd_req = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; upd_req = 1'b0;
      wait_done();
      chk(busy_len == FRAME, "R10 single transfer", busy_len, FRAME);

      chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
      chk(frames == 6, "R9 total frames", frames, 6);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule